// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Interface

This block is the per-processor interface of an interrupt controller. The distributor forwards a set of pending sources to it, each with a priority value. For software-generated sources (IDs 0 to 15) it also forwards the number of the CPU that raised them. The interface keeps its own record of which sources are in service. From the sources that are pending, not in service and numerically below the priority threshold, it picks one winner. It raises a single request line to the processor while a winner exists and signalling is enabled.

The processor uses a small 32-bit register port with separate read and write strobes. Reading the claim register returns the winner's ID and places that source in service. A pulse tells the distributor which ID was claimed. Writing an ID to the completion register takes that source out of service, with a matching pulse to the distributor. The claim returns the reserved value 1023 when nothing qualifies, when signalling is off, or when the winner's ID lies above the highest legal ID. In all three cases no state changes.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the enable bit and the threshold are 0, the request line is low, and a claim read returns 1023.
- R2: Word address 0 holds the enable in bit 0, and only that bit is writable. The request line is high exactly when the enable is 1 and at least one source is pending, not in service and below the threshold.
- R3: Word address 1 holds the 8-bit priority threshold. Only sources whose priority value is strictly less than it qualify.
- R4: Among qualifying sources the numerically lowest priority value wins, and a tie goes to the lowest ID.
- R5: A read of word address 2 (claim) returns the winner's ID in bits 9:0 one cycle later. It puts that source in service, which makes it ineligible, and it pulses ack_o for one cycle with ack_id_o set to the ID.
- R6: For a claimed ID of 0 to 15, bits 12:10 of the claim value carry that source's originating CPU. For higher IDs these bits are 0.
- R7: A claim with no qualifying source, or with the enable at 0, returns 1023. It leaves the in-service set unchanged and gives no ack_o pulse.
- R8: If the winner's ID exceeds MAX_ID, the claim returns 1023, no source is put in service, no ack_o pulse occurs, and the request line stays high.
- R9: Writing an ID to word address 3 (completion) takes that source out of service and pulses eoi_o with eoi_id_o. IDs at or above NUM_SRC are ignored, with no pulse.
- R10: A claim and a completion in the same cycle both take effect. The source being completed is still treated as in service when that claim picks its winner.
- R11: Writes to the claim register have no effect, and reads of the completion register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Register read word address |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |
| pend_i | input | NUM_SRC | Pending sources forwarded by the distributor |
| prio_i | input | NUM_SRC*PRIO_W | Priority value per source, source i at bits i*PRIO_W |
| sgi_src_i | input | 48 | Originating CPU per software source, 3 bits each |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Claim pulse to the distributor |
| ack_id_o | output | 10 | ID that was claimed |
| eoi_o | output | 1 | Completion pulse to the distributor |
| eoi_id_o | output | 10 | ID that was completed |

## Verification
A claim read and a completion write can both land on the same clock edge, because the port has independent read and write strobes. The bench first claims one source. It then issues a second claim together with the completion of that first source in a single cycle. That claim must return the next-best source and not the one being completed, and both pulses must appear. A further claim must then return the completed source, which shows that its in-service bit really was cleared.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  localparam int ID_W     = 10;
  localparam int CPU_W    = 3;
  localparam int NUM_SGI  = 16;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_CLAIM = 2'd2,
    REG_DONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpuif_cfg.sv
module cpuif_cfg #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] pmask_o
);
  import irq_cpu_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      pmask_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_CTRL)  en_o    <= wr_data_i[0];
      if (wr_addr_i == REG_PMASK) pmask_o <= wr_data_i[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/cpuif_arb.sv
module cpuif_arb #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              pmask_i,
  output logic                           found_o,
  output logic [SRC_W-1:0]               win_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found_o   = 1'b0;
    win_o     = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (prio_i[i] < pmask_i) &&
          (!found_o || (prio_i[i] < best_prio))) begin
        found_o   = 1'b1;
        win_o     = SRC_W'(i);
        best_prio = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [SRC_W-1:0]   set_idx_i,
  input  logic               clr_i,
  input  logic [SRC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] active_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_i && (set_idx_i == SRC_W'(g));
    assign hit_clr = clr_i && (clr_idx_i == SRC_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      active_o[g] <= 1'b0;
      else if (hit_set) active_o[g] <= 1'b1;
      else if (hit_clr) active_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter int MAX_ID  = 510
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_addr_i,
  input  logic [31:0]               wr_data_i,
  input  logic                      rd_en_i,
  input  logic [1:0]                rd_addr_i,
  output logic [31:0]               rd_data_o,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [47:0]               sgi_src_i,
  output logic                      irq_o,
  output logic                      ack_o,
  output logic [9:0]                ack_id_o,
  output logic                      eoi_o,
  output logic [9:0]                eoi_id_o
);
  import irq_cpu_pkg::*;

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam logic [ID_W:0] SRC_LIMIT = (ID_W+1)'(NUM_SRC);
  localparam logic [ID_W-1:0] ID_TOP  = ID_W'(MAX_ID);

  logic                           en_q;
  logic [PRIO_W-1:0]              pmask_q;
  logic [NUM_SRC-1:0]             active_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
  logic [NUM_SGI-1:0][CPU_W-1:0]  sgi_arr;
  logic                           found;
  logic [SRC_W-1:0]               win_idx;
  logic [ID_W-1:0]                win_id;
  logic                           in_range;
  logic                           claim_rd, claim_go;
  logic                           done_wr, done_go;
  logic [ID_W-1:0]                done_id;
  logic [CPU_W-1:0]               win_cpu;
  logic [31:0]                    rd_next;

  assign prio_arr = prio_i;
  assign sgi_arr  = sgi_src_i;

  cpuif_cfg #(.PRIO_W(PRIO_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o    (en_q),
    .pmask_o (pmask_q)
  );

  cpuif_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .cand_i  (pend_i & ~active_q),
    .prio_i  (prio_arr),
    .pmask_i (pmask_q),
    .found_o (found),
    .win_o   (win_idx)
  );

  assign win_id = ID_W'(win_idx);

  if (NUM_SRC > MAX_ID + 1) begin : g_rchk
    assign in_range = (win_id <= ID_TOP);
  end else begin : g_nochk
    assign in_range = 1'b1;
  end

  assign irq_o    = en_q && found;
  assign claim_rd = rd_en_i && (rd_addr_i == REG_CLAIM);
  assign claim_go = claim_rd && irq_o && in_range;
  assign done_wr  = wr_en_i && (wr_addr_i == REG_DONE);
  assign done_id  = wr_data_i[ID_W-1:0];
  assign done_go  = done_wr && ({1'b0, done_id} < SRC_LIMIT);
  assign win_cpu  = (win_id < ID_W'(NUM_SGI)) ? sgi_arr[win_idx[3:0]] : '0;

  cpuif_active #(.NUM_SRC(NUM_SRC)) u_act (
    .clk_i, .rst_ni,
    .set_i     (claim_go),
    .set_idx_i (win_idx),
    .clr_i     (done_go),
    .clr_idx_i (done_id[SRC_W-1:0]),
    .active_o  (active_q)
  );

  always_comb begin
    rd_next = '0;
    unique case (rd_addr_i)
      REG_CTRL:  rd_next = {31'b0, en_q};
      REG_PMASK: rd_next = 32'(pmask_q);
      REG_CLAIM: rd_next = claim_go ? {19'b0, win_cpu, win_id} : 32'(SPURIOUS_ID);
      REG_DONE:  rd_next = '0;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      ack_o     <= 1'b0;
      ack_id_o  <= '0;
      eoi_o     <= 1'b0;
      eoi_id_o  <= '0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_next;
      ack_o <= claim_go;
      eoi_o <= done_go;
      if (claim_go) ack_id_o <= win_id;
      if (done_go)  eoi_id_o <= done_id;
    end
  end
endmodule

// File: rtl/irq_cpu_port_chk.sv
module irq_cpu_port_chk #(
  parameter int NUM_SRC = 64,
  parameter int MAX_ID  = 510
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_q,
  input logic               irq_o,
  input logic               ack_o,
  input logic [9:0]         ack_id_o,
  input logic               eoi_o,
  input logic [9:0]         eoi_id_o,
  input logic               rd_en_i,
  input logic [1:0]         rd_addr_i,
  input logic [31:0]        rd_data_o,
  input logic [NUM_SRC-1:0] active_q
);
  logic ack_bit, eoi_bit;
  assign ack_bit = (active_q >> ack_id_o) != '0 && active_q[ack_id_o[$clog2(NUM_SRC)-1:0]];
  assign eoi_bit = active_q[eoi_id_o[$clog2(NUM_SRC)-1:0]];

  assert_irq_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o);

  assert_ack_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(irq_o));

  assert_ack_marks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_bit);

  assert_eoi_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o && !(ack_o && ack_id_o == eoi_id_o)) |-> !eoi_bit);

  assert_spurious_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_en_i && rd_addr_i == 2'd2) && rd_data_o[9:0] == 10'd1023) |-> !ack_o);

  assert_ack_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ack_id_o <= 10'(MAX_ID)));
endmodule

bind irq_cpu_port irq_cpu_port_chk #(.NUM_SRC(NUM_SRC), .MAX_ID(MAX_ID)) u_chk (
  .clk_i, .rst_ni, .en_q, .irq_o, .ack_o, .ack_id_o, .eoi_o, .eoi_id_o,
  .rd_en_i, .rd_addr_i, .rd_data_o, .active_q
);

// File: tb/irq_cpu_port_tb.sv
module irq_cpu_port_tb;
  localparam int NS = 32;
  localparam int PW = 8;
  localparam int MX = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [NS-1:0] pend = '0;
  logic [NS-1:0][PW-1:0] prio = '0;
  logic [15:0][2:0] sgi = '0;
  logic irq, ack, eoi;
  logic [9:0] ack_id, eoi_id;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  irq_cpu_port #(.NUM_SRC(NS), .PRIO_W(PW), .MAX_ID(MX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pend_i(pend), .prio_i(prio), .sgi_src_i(sgi),
    .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id), .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  // claim, checking value and acknowledge pulse
  task automatic claim(string req, logic [31:0] exp, logic exp_ack);
    logic [31:0] d;
    rd(2'd2, d);
    chk(req, d, exp);
    chk(req, {31'b0, ack}, {31'b0, exp_ack});
    if (exp_ack) chk(req, {22'b0, ack_id}, exp & 32'h3ff);
  endtask

  task automatic done(string req, logic [9:0] id, logic exp_pulse);
    wr(2'd3, {22'b0, id});
    chk(req, {31'b0, eoi}, {31'b0, exp_pulse});
    if (exp_pulse) chk(req, {22'b0, eoi_id}, {22'b0, id});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 pmask", d, 0);
    claim("R1 claim", 1023, 0);
  endtask

  task automatic t_enable_mask;
    prio[20] = 8'h80; pend[20] = 1;
    wr(2'd1, 32'hF0);
    #1 chk("R2 disabled irq low", {31'b0, irq}, 0);
    claim("R7 disabled claim", 1023, 0);
    wr(2'd0, 1);
    #1 chk("R2 enabled irq high", {31'b0, irq}, 1);
    wr(2'd1, 32'h80);
    #1 chk("R3 equal prio masked", {31'b0, irq}, 0);
    claim("R7 masked claim", 1023, 0);
    wr(2'd1, 32'h81);
    #1 chk("R3 below mask", {31'b0, irq}, 1);
    wr(2'd1, 32'hF0);
    pend[20] = 0;
    #1 chk("R2 nothing pending", {31'b0, irq}, 0);
  endtask

  task automatic t_arb;
    prio[18] = 8'h40; prio[25] = 8'h20; prio[22] = 8'h20;
    pend[18] = 1; pend[25] = 1; pend[22] = 1;
    claim("R4 tie lowest id", 22, 1);
    claim("R4 next", 25, 1);
    claim("R5 active excluded", 18, 1);
    #1 chk("R5 irq low all active", {31'b0, irq}, 0);
    claim("R7 none eligible", 1023, 0);
    pend[18] = 0; pend[25] = 0; pend[22] = 0;
    done("R9 eoi 22", 22, 1);
    done("R9 eoi 25", 25, 1);
    done("R9 eoi 18", 18, 1);
  endtask

  task automatic t_sgi;
    sgi[3] = 3'd5; prio[3] = 8'h10; pend[3] = 1;
    claim("R6 sgi source cpu", 32'h1403, 1);
    pend[3] = 0;
    done("R9 eoi sgi", 3, 1);
  endtask

  task automatic t_range;
    prio[31] = 8'h10; pend[31] = 1; prio[20] = 8'h30; pend[20] = 1;
    claim("R8 out of range", 1023, 0);
    #1 chk("R8 irq stays high", {31'b0, irq}, 1);
    claim("R8 no state change", 1023, 0);
    pend[31] = 0;
    claim("R8 next legal", 20, 1);
    pend[20] = 0;
    done("R9 eoi 20", 20, 1);
    done("R9 id beyond sources ignored", 10'd40, 0);
  endtask

  task automatic t_collide;
    prio[17] = 8'h10; prio[19] = 8'h20; pend[17] = 1; pend[19] = 1;
    claim("R10 first", 17, 1);
    @(negedge clk);
    rd_en = 1; rd_addr = 2'd2; wr_en = 1; wr_addr = 2'd3; wr_data = 17;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    chk("R10 claim skips completing", rd_data, 19);
    chk("R10 ack pulse", {31'b0, ack}, 1);
    chk("R10 eoi pulse", {31'b0, eoi}, 1);
    chk("R10 eoi id", {22'b0, eoi_id}, 17);
    claim("R10 completed reclaimable", 17, 1);
    pend[17] = 0; pend[19] = 0;
    done("R9 eoi 17", 17, 1);
    done("R9 eoi 19", 19, 1);
    #1 chk("R2 idle", {31'b0, irq}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R11 claim write no ctrl effect", d, 1);
    rd(2'd1, d); chk("R11 claim write no pmask effect", d, 32'hF0);
    rd(2'd3, d); chk("R11 done reads zero", d, 0);
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, d); chk("R2 only bit0", d, 0);
    wr(2'd1, 32'h1AB);
    rd(2'd1, d); chk("R3 pmask 8 bits", d, 32'hAB);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_enable_mask;
    t_arb;
    t_sgi;
    t_range;
    t_collide;
    t_regs;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule